// File: doc/BRIEF.md
# Slot-Table Time-Division Memory Arbiter

This block shares a single memory port among up to fifteen requesters. Bandwidth is reserved through a table of sixty-four time slots, each holding the index of the client that owns it. A slot pointer walks the table one entry at a time. When the pointer rests on a slot whose owner is requesting, that owner wins. When the owner is idle, or the slot has no owner, the slot goes to the requesting client with the lowest index.

A winning client holds a one-hot grant for one burst. The burst ends when the client marks its final beat, or when the client's programmable beat limit is reached, whichever happens first. The pointer then moves to the next slot. Software fills the slot table and the per-client limits through a simple write port. Any entry may be rewritten while arbitration runs.

Top module: `tdm_slot_arbiter`

## Requirements
- R1: After reset, `gnt` is zero and `slot_ptr` is 0. Every table entry holds 15 (no owner), and every client's limit holds 3.
- R2: In a cycle with no grant held, if the entry at `slot_ptr` names client c (c < 15) and `req[c]` is high, then `gnt` is exactly bit c from the next cycle on, whatever the other requests are.
- R3: In a cycle with no grant held and some request high, if the current entry is 15 or names a client that is not requesting, the grant goes to the lowest-index client whose `req` bit is high.
- R4: `gnt` is zero or one-hot. It rises only for a client that was requesting in the arbitration cycle, and it stays unchanged for every beat of the burst.
- R5: Each cycle with `gnt` nonzero is one beat. The burst ends after the beat in which `xfer_last` is high, or after limit+1 beats, whichever comes first. `gnt` is low for at least one cycle between bursts.
- R6: `slot_ptr` holds still during a burst. It advances by one in the cycle the burst ends, and it wraps from 63 to 0.
- R7: In a cycle with no grant held and no request high, no grant is issued and `slot_ptr` advances by one.
- R8: A write with `cfg_we`=1 and `cfg_sel`=0 stores `cfg_data` into the table entry selected by `cfg_addr` (0 to 63). The new owner is used the next time the pointer arbitrates at that slot, including when the write lands after the pointer has just passed it.
- R9: A write with `cfg_we`=1 and `cfg_sel`=1 stores `cfg_data` as the limit of client `cfg_addr` (0 to 14). A limit of L allows at most L+1 beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 15 | Per-client request |
| xfer_last | input | 1 | High on the final beat of the granted client's burst |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the slot table, 1 selects the client limits |
| cfg_addr | input | 6 | Slot index, or client index in bits 3:0 |
| cfg_data | input | 4 | Owner index or beat limit |
| gnt | output | 15 | One-hot grant |
| slot_ptr | output | 6 | Current slot index |

## Verification
The hardest case to reach is a table rewrite that only becomes visible a full pass later. The bench writes the entry under the pointer while no one is requesting, so the pointer steps past it. It then idles 63 cycles to bring the pointer back around through the 63-to-0 wrap, and requests from both the new owner and a lower-index client. It also mixes owned, unowned and idle-owner slots with early final-beat marks and small and large limits, so that both ways of ending a burst are checked against a bench model of the table.

// File: rtl/tdm_slot_arbiter.sv
module tdm_slot_arbiter #(
  parameter int NCLI    = 15,
  parameter int NSLOT   = 64,
  parameter int LIMW    = 4,
  parameter int LIM_RST = 3,
  localparam int IW = $clog2(NCLI + 1),
  localparam int PW = $clog2(NSLOT),
  localparam int DW = (IW > LIMW) ? IW : LIMW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLI-1:0] req,
  input  logic            xfer_last,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [PW-1:0]   cfg_addr,
  input  logic [DW-1:0]   cfg_data,
  output logic [NCLI-1:0] gnt,
  output logic [PW-1:0]   slot_ptr
);

  localparam int RW = 1 << IW;

  logic [IW-1:0]   tbl [NSLOT];
  logic [LIMW-1:0] lim [NCLI];
  logic [IW-1:0]   cur;
  logic [LIMW-1:0] cnt;
  logic [IW-1:0]   owner, fb, win;
  logic [RW-1:0]   req_x;
  logic            busy, owner_hit, end_now;
  logic [PW-1:0]   ptr_nxt;

  assign req_x     = RW'(req);
  assign busy      = |gnt;
  assign owner     = tbl[slot_ptr];
  assign owner_hit = (32'(owner) < NCLI) && req_x[owner];
  assign win       = owner_hit ? owner : fb;
  assign end_now   = busy && (xfer_last || cnt == lim[cur]);
  assign ptr_nxt   = (32'(slot_ptr) == NSLOT - 1) ? '0 : slot_ptr + 1'b1;

  always_comb begin
    fb = '0;
    for (int i = NCLI - 1; i >= 0; i--)
      if (req[i]) fb = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt      <= '0;
      slot_ptr <= '0;
      cur      <= '0;
      cnt      <= '0;
    end else if (busy) begin
      if (end_now) begin
        gnt      <= '0;
        slot_ptr <= ptr_nxt;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (|req) begin
      gnt <= NCLI'(1) << win;
      cur <= win;
      cnt <= '0;
    end else begin
      slot_ptr <= ptr_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) tbl[s] <= '1;
      for (int c = 0; c < NCLI; c++)  lim[c] <= LIMW'(LIM_RST);
    end else if (cfg_we) begin
      if (!cfg_sel)
        tbl[cfg_addr] <= cfg_data[IW-1:0];
      else if (32'(cfg_addr) < NCLI)
        lim[cfg_addr[IW-1:0]] <= cfg_data[LIMW-1:0];
    end
  end

  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r4_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && |req) |=> (gnt & $past(req)) != '0);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !end_now) |=> $stable(gnt));

  a_r2_owner_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && owner_hit) |=> gnt == (NCLI'(1) << $past(owner)));

  a_r5_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= lim[cur]);

  a_r5_gap: assert property (@(posedge clk) disable iff (!rst_n)
    end_now |=> gnt == '0);

  a_r6_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !end_now) |=> $stable(slot_ptr));

  a_r7_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req == '0) |=> (gnt == '0 &&
      slot_ptr == ((32'($past(slot_ptr)) == NSLOT - 1) ? '0 : $past(slot_ptr) + 1'b1)));

endmodule

// File: tb/sim_tdm_slot_arbiter.sv
`timescale 1ns/1ps
module sim_tdm_slot_arbiter;
  logic        clk = 0, rst_n = 0;
  logic [14:0] req = '0;
  logic        xfer_last = 0, cfg_we = 0, cfg_sel = 0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_data = '0;
  logic [14:0] gnt;
  logic [5:0]  slot_ptr;

  tdm_slot_arbiter u0 (.clk(clk), .rst_n(rst_n), .req(req), .xfer_last(xfer_last),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .gnt(gnt), .slot_ptr(slot_ptr));

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  int eptr = 0;
  int btbl [64];
  int blim [15];
  int q_cli[$], q_len[$], q_ptr[$];
  string q_tag[$];

  function automatic int idx_of(input logic [14:0] v);
    for (int i = 0; i < 15; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input int addr, input int data);
    cfg_we = 1; cfg_sel = sel; cfg_addr = 6'(addr); cfg_data = 4'(data); req = '0;
    @(negedge clk);
    cfg_we = 0;
    if (!sel) btbl[addr] = data; else if (addr < 15) blim[addr] = data;
    eptr = (eptr + 1) % 64;
  endtask

  task automatic idle(input int n, input string tag);
    req = '0;
    repeat (n) @(negedge clk);
    eptr = (eptr + n) % 64;
    chk(slot_ptr == 6'(eptr), {tag, " ptr"}, slot_ptr, eptr);
    chk(gnt == '0, {tag, " no grant"}, gnt, 0);
  endtask

  task automatic burst(input logic [14:0] r, input int last_beat, input string tag);
    int own, w, len, beat, guard;
    own = btbl[eptr];
    w = -1;
    if (own < 15 && r[own]) w = own;
    else for (int i = 14; i >= 0; i--) if (r[i]) w = i;
    len = blim[w] + 1;
    if (last_beat > 0 && last_beat < len) len = last_beat;
    q_cli.push_back(w); q_len.push_back(len); q_ptr.push_back(eptr); q_tag.push_back(tag);
    eptr = (eptr + 1) % 64;
    req = r; beat = 0; guard = 0;
    while (beat < len && guard < 100) begin
      @(negedge clk);
      guard++;
      xfer_last = 0;
      if (gnt != '0) begin
        beat++;
        if (beat == len) req = '0;
        if (last_beat > 0 && beat == last_beat) xfer_last = 1;
      end
    end
    @(negedge clk);
    xfer_last = 0;
    req = '0;
  endtask

  int m_len = 0, m_cli = 0, m_ptr = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (gnt != '0) begin
        if (m_len == 0) begin
          m_cli = idx_of(gnt); m_ptr = slot_ptr;
        end else if (gnt != (15'(1) << m_cli)) begin
          chk(0, "R4 grant changed in burst", idx_of(gnt), m_cli);
        end
        if ($countones(gnt) != 1) chk(0, "R4 onehot", $countones(gnt), 1);
        m_len++;
      end else if (m_len > 0) begin
        if (q_cli.size() == 0) chk(0, "R4 unexpected burst", m_cli, -1);
        else begin
          int ec, el, ep; string t;
          ec = q_cli.pop_front(); el = q_len.pop_front();
          ep = q_ptr.pop_front(); t = q_tag.pop_front();
          chk(m_cli == ec, {t, " client"}, m_cli, ec);
          chk(m_len == el, {t, " beats (R5)"}, m_len, el);
          chk(m_ptr == ep, {t, " slot (R6)"}, m_ptr, ep);
        end
        m_len = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < 64; s++) btbl[s] = 15;
    for (int c = 0; c < 15; c++) blim[c] = 3;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(gnt == '0, "R1 reset grant", gnt, 0);
    chk(slot_ptr == '0, "R1 reset ptr", slot_ptr, 0);
    burst(15'h0006, 0, "R1 R3 fallback, default limit");
    burst(15'h7fff, 2, "R5 early last");
    wr(0, 10, 5);
    wr(0, 11, 9);
    wr(0, 12, 14);
    wr(1, 5, 1);
    wr(1, 9, 0);
    wr(1, 14, 7);
    idle(2, "R7 idle step");
    burst(15'h0222, 0, "R2 owner beats lower index, R9");
    burst(15'h0022, 0, "R3 idle owner");
    burst(15'h4200, 0, "R2 R9 long limit");
    burst(15'h4200, 0, "R3 no-owner slot, R9 one beat");
    burst(15'h4001, 5, "R5 limit before last");
    wr(0, 15, 14);
    idle(63, "R6 wrap");
    burst(15'h4001, 0, "R8 rewritten slot");
    burst(15'h4001, 0, "R8 neighbour slot unchanged");
    repeat (3) @(negedge clk);
    chk(q_cli.size() == 0, "R4 missing bursts", q_cli.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule